// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches virtual-to-physical page translations for a small processor core. It has a single direct-mapped array of physical page numbers. Three independent tag arrays sit beside it: one answers instruction fetches, one answers loads and one answers stores. A page counts as present for an access type only when that type's own tag matches. When the tag does not match, the block sends the address to an external page walker over a valid/ready pair. It then waits for the walker's answer. On success it installs the page. On failure it returns an access fault whose cause follows the access type.

A lookup can skip translation altogether. This happens when paging is switched off. It also happens in machine mode when the access is a fetch, or when the effective-privilege field selects machine mode. In those cases the physical address is the virtual address. A flush input wipes every tag. A flush that arrives while a walk is outstanding stops that walk's result from being cached. The requester still receives the result.

Requests are accepted one at a time. The response for an accepted request is a single-cycle pulse on `rsp_valid_o`. No new request is taken until the response for the current one has been produced.

Top module: `tlb_split_tag`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` and `walk_req_valid_o` are 0. Every tag is invalid, so the first translated access to any page goes to the walker.
- R2: The entry index is the virtual page number modulo ENTRIES (its low bits), and the stored tag is the whole virtual page number. A second page with the same index replaces the first one's tag for that access type.
- R3: A lookup whose access-type tag matches gives `rsp_valid_o`=1 with `rsp_hit_o`=1 in the cycle after acceptance. The paddr is the stored page number joined to the 12-bit page offset, and no walk is requested.
- R4: Access types are encoded on `req_kind_i` as 00 load, 01 store, 10 fetch, and 11 acts as load. A page installed for one type still misses for the other types until they install it themselves.
- R5: A refill at an index invalidates every other type's tag there that differs from the new page. Tags that equal the new page are kept. Only the current type's tag is written.
- R6: On a miss, `walk_req_valid_o` rises in the cycle after acceptance with `walk_vaddr_o` equal to the request address. It stays up, with a stable address, until `walk_req_ready_i`. `req_ready_o` stays 0 until the response has been produced.
- R7: A successful walker reply (`walk_rsp_ok_i`=1) installs the entry. In the next cycle it gives `rsp_valid_o`=1, `rsp_hit_o`=0, `rsp_cause_o`=00, and paddr = {returned page number, offset}.
- R8: A failed reply gives `rsp_valid_o`=1 with `rsp_cause_o` = 01 for a fetch, 11 for a store and 10 otherwise. `rsp_vaddr_o` carries the faulting address and `rsp_hit_o` is 0. No entry is written.
- R9: `flush_i` invalidates all tags of all three types, and `req_ready_o` is 0 during the flush cycle.
- R10: If `flush_i` is seen while a walk is outstanding, the reply is still returned to the requester but is not installed.
- R11: Privilege is encoded 00 user, 01 supervisor, 11 machine (10 acts as user). Translation is skipped when `vm_on_i`=0, or when `priv_i`=11 and (the access is a fetch or `mprv_i`=11). In that case the reply arrives the next cycle with `rsp_hit_o`=1 and paddr equal to vaddr.
- R12: `walk_super_o` is 1 exactly when `priv_i` is supervisor, or when `priv_i` is machine and `mprv_i` is supervisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate every tag |
| vm_on_i | input | 1 | Paging enabled |
| priv_i | input | 2 | Current privilege mode |
| mprv_i | input | 2 | Effective-privilege field for data accesses in machine mode |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup can be accepted |
| req_vaddr_i | input | VA_W | Virtual address of the lookup |
| req_kind_i | input | 2 | Access type |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_hit_o | output | 1 | Answered without a walk |
| rsp_cause_o | output | 2 | Fault cause, 00 when none |
| rsp_paddr_o | output | PA_W | Physical address |
| rsp_vaddr_o | output | VA_W | Virtual address of the answered request |
| walk_req_valid_o | output | 1 | Walk request valid |
| walk_req_ready_i | input | 1 | Walker accepts the request |
| walk_vaddr_o | output | VA_W | Address to translate |
| walk_kind_o | output | 2 | Access type for permission checks |
| walk_super_o | output | 1 | Walk with supervisor permissions |
| walk_rsp_valid_i | input | 1 | Walker reply valid |
| walk_rsp_ok_i | input | 1 | Walk succeeded |
| walk_rsp_ppn_i | input | PA_W-PAGE_SHIFT | Physical page number from the walker |

## Verification
A hit or a bypassed lookup answers one clock after the accepting edge. A miss raises the walk request one clock after that edge, and the final response follows the walker's reply by one clock. The bench drives every input on the falling edge and waits exactly one clock after each accepting or handshake edge before it samples, so each result is read in the cycle where it is due. The stall is checked while the walk is outstanding. The flush-cycle ready drop is read inside that same cycle.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

    localparam logic [1:0] KIND_LOAD  = 2'b00;
    localparam logic [1:0] KIND_STORE = 2'b01;
    localparam logic [1:0] KIND_FETCH = 2'b10;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam int NUM_BANKS = 3;
    localparam logic [1:0] BANK_FETCH = 2'd0;
    localparam logic [1:0] BANK_LOAD  = 2'd1;
    localparam logic [1:0] BANK_STORE = 2'd2;

    localparam logic [1:0] CAUSE_NONE  = 2'b00;
    localparam logic [1:0] CAUSE_FETCH = 2'b01;
    localparam logic [1:0] CAUSE_LOAD  = 2'b10;
    localparam logic [1:0] CAUSE_STORE = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WREQ  = 2'd1,
        ST_WWAIT = 2'd2
    } ctl_state_e;

    // Tag bank that answers a given access type; reserved code acts as load.
    function automatic logic [1:0] bank_of(input logic [1:0] kind);
        case (kind)
            KIND_FETCH: return BANK_FETCH;
            KIND_STORE: return BANK_STORE;
            default:    return BANK_LOAD;
        endcase
    endfunction

    function automatic logic [1:0] cause_of(input logic [1:0] kind);
        case (kind)
            KIND_FETCH: return CAUSE_FETCH;
            KIND_STORE: return CAUSE_STORE;
            default:    return CAUSE_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/tlb_tag_bank.sv
`timescale 1ns/1ps
module tlb_tag_bank #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 21,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [TAG_W-1:0] rd_tag_o,
    input  logic             wr_en_i,
    input  logic             wr_own_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i
);

    localparam logic [TAG_W-1:0] TAG_INVALID = '1;

    typedef struct {
        logic [TAG_W-1:0] tag [ENTRIES];
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flush_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                s_d.tag[i] = TAG_INVALID;
            end
        end else if (wr_en_i) begin
            if (wr_own_i) begin
                s_d.tag[wr_idx_i] = wr_tag_i;
            end else if (s_q.tag[wr_idx_i] != wr_tag_i) begin
                s_d.tag[wr_idx_i] = TAG_INVALID;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                s_q.tag[i] <= TAG_INVALID;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_tag_o = s_q.tag[rd_idx_i];

endmodule

// File: rtl/tlb_data_bank.sv
`timescale 1ns/1ps
module tlb_data_bank #(
    parameter int ENTRIES = 16,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [PPN_W-1:0] rd_ppn_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [PPN_W-1:0] wr_ppn_i
);

    typedef struct {
        logic [PPN_W-1:0] ppn [ENTRIES];
    } data_t;

    data_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            s_d.ppn[wr_idx_i] = wr_ppn_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                s_q.ppn[i] <= '0;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_ppn_o = s_q.ppn[rd_idx_i];

endmodule

// File: rtl/tlb_ctrl.sv
`timescale 1ns/1ps
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int VPN_W     = VA_W - PAGE_SHIFT,
    localparam int PPN_W     = PA_W - PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             vm_on_i,
    input  logic [1:0]       priv_i,
    input  logic [1:0]       mprv_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic [1:0]       req_kind_i,
    input  logic             lookup_hit_i,
    input  logic [PPN_W-1:0] lookup_ppn_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic [1:0]       rsp_cause_o,
    output logic [PA_W-1:0]  rsp_paddr_o,
    output logic [VA_W-1:0]  rsp_vaddr_o,
    output logic             walk_req_valid_o,
    input  logic             walk_req_ready_i,
    output logic [VA_W-1:0]  walk_vaddr_o,
    output logic [1:0]       walk_kind_o,
    output logic             walk_super_o,
    input  logic             walk_rsp_valid_i,
    input  logic             walk_rsp_ok_i,
    input  logic [PPN_W-1:0] walk_rsp_ppn_i,
    output logic             walk_busy_o,
    output logic             refill_en_o,
    output logic [VPN_W-1:0] refill_vpn_o,
    output logic [1:0]       refill_kind_o,
    output logic [PPN_W-1:0] refill_ppn_o
);

    typedef struct packed {
        ctl_state_e      st;
        logic [VA_W-1:0] vaddr;
        logic [1:0]      kind;
        logic            sup;
        logic            stale;
        logic            rv;
        logic            rhit;
        logic [1:0]      rcause;
        logic [PA_W-1:0] rpa;
    } ctl_t;

    ctl_t c_d, c_q;

    logic accept, bypass, sup_now, ready;

    always_comb begin
        ready   = (c_q.st == ST_IDLE) && !flush_i;
        accept  = req_valid_i && ready;
        bypass  = !vm_on_i ||
                  ((priv_i == PRIV_M) && ((req_kind_i == KIND_FETCH) || (mprv_i == PRIV_M)));
        sup_now = (priv_i == PRIV_S) || ((priv_i == PRIV_M) && (mprv_i == PRIV_S));

        c_d    = c_q;
        c_d.rv = 1'b0;

        case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    c_d.vaddr  = req_vaddr_i;
                    c_d.kind   = req_kind_i;
                    c_d.sup    = sup_now;
                    c_d.stale  = 1'b0;
                    c_d.rcause = CAUSE_NONE;
                    if (bypass) begin
                        c_d.rv   = 1'b1;
                        c_d.rhit = 1'b1;
                        c_d.rpa  = PA_W'(req_vaddr_i);
                    end else if (lookup_hit_i) begin
                        c_d.rv   = 1'b1;
                        c_d.rhit = 1'b1;
                        c_d.rpa  = {lookup_ppn_i, req_vaddr_i[PAGE_SHIFT-1:0]};
                    end else begin
                        c_d.st = ST_WREQ;
                    end
                end
            end
            ST_WREQ: begin
                if (flush_i) c_d.stale = 1'b1;
                if (walk_req_ready_i) c_d.st = ST_WWAIT;
            end
            ST_WWAIT: begin
                if (flush_i) c_d.stale = 1'b1;
                if (walk_rsp_valid_i) begin
                    c_d.st   = ST_IDLE;
                    c_d.rv   = 1'b1;
                    c_d.rhit = 1'b0;
                    if (walk_rsp_ok_i) begin
                        c_d.rcause = CAUSE_NONE;
                        c_d.rpa    = {walk_rsp_ppn_i, c_q.vaddr[PAGE_SHIFT-1:0]};
                    end else begin
                        c_d.rcause = cause_of(c_q.kind);
                        c_d.rpa    = '0;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready_o      = ready;
    assign rsp_valid_o      = c_q.rv;
    assign rsp_hit_o        = c_q.rhit;
    assign rsp_cause_o      = c_q.rcause;
    assign rsp_paddr_o      = c_q.rpa;
    assign rsp_vaddr_o      = c_q.vaddr;
    assign walk_req_valid_o = (c_q.st == ST_WREQ);
    assign walk_vaddr_o     = c_q.vaddr;
    assign walk_kind_o      = c_q.kind;
    assign walk_super_o     = c_q.sup;
    assign walk_busy_o      = (c_q.st == ST_WWAIT);

    // A flush in the reply cycle or earlier in the walk blocks the install.
    assign refill_en_o   = (c_q.st == ST_WWAIT) && walk_rsp_valid_i && walk_rsp_ok_i &&
                           !c_q.stale && !flush_i;
    assign refill_vpn_o  = c_q.vaddr[VA_W-1:PAGE_SHIFT];
    assign refill_kind_o = c_q.kind;
    assign refill_ppn_o  = walk_rsp_ppn_i;

endmodule

// File: rtl/tlb_split_tag.sv
`timescale 1ns/1ps
module tlb_split_tag
    import tlb_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRIES    = 16,
    localparam int VPN_W     = VA_W - PAGE_SHIFT,
    localparam int PPN_W     = PA_W - PAGE_SHIFT,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int TAG_W     = VPN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             vm_on_i,
    input  logic [1:0]       priv_i,
    input  logic [1:0]       mprv_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic [1:0]       req_kind_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic [1:0]       rsp_cause_o,
    output logic [PA_W-1:0]  rsp_paddr_o,
    output logic [VA_W-1:0]  rsp_vaddr_o,
    output logic             walk_req_valid_o,
    input  logic             walk_req_ready_i,
    output logic [VA_W-1:0]  walk_vaddr_o,
    output logic [1:0]       walk_kind_o,
    output logic             walk_super_o,
    input  logic             walk_rsp_valid_i,
    input  logic             walk_rsp_ok_i,
    input  logic [PPN_W-1:0] walk_rsp_ppn_i
);

    logic [VPN_W-1:0] req_vpn;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] want_tag, new_tag;
    logic [TAG_W-1:0] rd_tag [NUM_BANKS];
    logic [TAG_W-1:0] sel_tag;
    logic [PPN_W-1:0] rd_ppn;
    logic             lookup_hit;
    logic             walk_busy;
    logic             refill_en;
    logic [VPN_W-1:0] refill_vpn;
    logic [1:0]       refill_kind;
    logic [PPN_W-1:0] refill_ppn;

    // Tags carry a leading zero so the all-ones marker never equals a real page.
    assign req_vpn  = req_vaddr_i[VA_W-1:PAGE_SHIFT];
    assign rd_idx   = req_vpn[IDX_W-1:0];
    assign want_tag = {1'b0, req_vpn};
    assign wr_idx   = refill_vpn[IDX_W-1:0];
    assign new_tag  = {1'b0, refill_vpn};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic own;
        assign own = (bank_of(refill_kind) == 2'(b));
        tlb_tag_bank #(
            .ENTRIES (ENTRIES),
            .TAG_W   (TAG_W)
        ) u_tags (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush_i  (flush_i),
            .rd_idx_i (rd_idx),
            .rd_tag_o (rd_tag[b]),
            .wr_en_i  (refill_en),
            .wr_own_i (own),
            .wr_idx_i (wr_idx),
            .wr_tag_i (new_tag)
        );
    end

    always_comb begin
        case (bank_of(req_kind_i))
            BANK_FETCH: sel_tag = rd_tag[0];
            BANK_STORE: sel_tag = rd_tag[2];
            default:    sel_tag = rd_tag[1];
        endcase
        lookup_hit = (sel_tag == want_tag);
    end

    tlb_data_bank #(
        .ENTRIES (ENTRIES),
        .PPN_W   (PPN_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_i (rd_idx),
        .rd_ppn_o (rd_ppn),
        .wr_en_i  (refill_en),
        .wr_idx_i (wr_idx),
        .wr_ppn_i (refill_ppn)
    );

    tlb_ctrl #(
        .VA_W       (VA_W),
        .PA_W       (PA_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .flush_i          (flush_i),
        .vm_on_i          (vm_on_i),
        .priv_i           (priv_i),
        .mprv_i           (mprv_i),
        .req_valid_i      (req_valid_i),
        .req_ready_o      (req_ready_o),
        .req_vaddr_i      (req_vaddr_i),
        .req_kind_i       (req_kind_i),
        .lookup_hit_i     (lookup_hit),
        .lookup_ppn_i     (rd_ppn),
        .rsp_valid_o      (rsp_valid_o),
        .rsp_hit_o        (rsp_hit_o),
        .rsp_cause_o      (rsp_cause_o),
        .rsp_paddr_o      (rsp_paddr_o),
        .rsp_vaddr_o      (rsp_vaddr_o),
        .walk_req_valid_o (walk_req_valid_o),
        .walk_req_ready_i (walk_req_ready_i),
        .walk_vaddr_o     (walk_vaddr_o),
        .walk_kind_o      (walk_kind_o),
        .walk_super_o     (walk_super_o),
        .walk_rsp_valid_i (walk_rsp_valid_i),
        .walk_rsp_ok_i    (walk_rsp_ok_i),
        .walk_rsp_ppn_i   (walk_rsp_ppn_i),
        .walk_busy_o      (walk_busy),
        .refill_en_o      (refill_en),
        .refill_vpn_o     (refill_vpn),
        .refill_kind_o    (refill_kind),
        .refill_ppn_o     (refill_ppn)
    );

endmodule

// File: rtl/tlb_split_tag_chk.sv
`timescale 1ns/1ps
module tlb_split_tag_chk #(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vm_on_i,
    input logic            req_valid_i,
    input logic            req_ready_o,
    input logic [VA_W-1:0] req_vaddr_i,
    input logic            rsp_valid_o,
    input logic            rsp_hit_o,
    input logic [1:0]      rsp_cause_o,
    input logic [PA_W-1:0] rsp_paddr_o,
    input logic            walk_req_valid_o,
    input logic            walk_req_ready_i,
    input logic [VA_W-1:0] walk_vaddr_o,
    input logic            walk_busy,
    input logic            walk_rsp_valid_i,
    input logic            walk_rsp_ok_i
);

    // R6
    stall_on_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid_o || walk_busy) |-> !req_ready_o);

    // R6
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid_o && !walk_req_ready_i) |=> (walk_req_valid_o && $stable(walk_vaddr_o)));

    // R3
    accept_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> (rsp_valid_o || walk_req_valid_o));

    // R11
    bypass_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !vm_on_i) |=>
        (rsp_valid_o && rsp_hit_o && (rsp_paddr_o[PAGE_SHIFT-1:0] == $past(req_vaddr_i[PAGE_SHIFT-1:0]))));

    // R7
    walk_reply_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && walk_rsp_valid_i && walk_rsp_ok_i) |=>
        (rsp_valid_o && !rsp_hit_o && (rsp_cause_o == 2'b00)));

    // R8
    walk_reply_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && walk_rsp_valid_i && !walk_rsp_ok_i) |=>
        (rsp_valid_o && !rsp_hit_o && (rsp_cause_o != 2'b00)));

    // R8
    fault_not_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && (rsp_cause_o != 2'b00)) |-> !rsp_hit_o);

endmodule

bind tlb_split_tag tlb_split_tag_chk #(
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .vm_on_i          (vm_on_i),
    .req_valid_i      (req_valid_i),
    .req_ready_o      (req_ready_o),
    .req_vaddr_i      (req_vaddr_i),
    .rsp_valid_o      (rsp_valid_o),
    .rsp_hit_o        (rsp_hit_o),
    .rsp_cause_o      (rsp_cause_o),
    .rsp_paddr_o      (rsp_paddr_o),
    .walk_req_valid_o (walk_req_valid_o),
    .walk_req_ready_i (walk_req_ready_i),
    .walk_vaddr_o     (walk_vaddr_o),
    .walk_busy        (walk_busy),
    .walk_rsp_valid_i (walk_rsp_valid_i),
    .walk_rsp_ok_i    (walk_rsp_ok_i)
);

// File: tb/tb_tlb_split_tag.sv
`timescale 1ns/1ps
module tb_tlb_split_tag;

    localparam logic [1:0] K_LOAD  = 2'b00;
    localparam logic [1:0] K_STORE = 2'b01;
    localparam logic [1:0] K_FETCH = 2'b10;
    localparam logic [1:0] P_U = 2'b00;
    localparam logic [1:0] P_S = 2'b01;
    localparam logic [1:0] P_M = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        vm_on_i = 1'b1;
    logic [1:0]  priv_i = P_S;
    logic [1:0]  mprv_i = P_U;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] req_vaddr_i = '0;
    logic [1:0]  req_kind_i = K_LOAD;
    logic        rsp_valid_o, rsp_hit_o;
    logic [1:0]  rsp_cause_o;
    logic [31:0] rsp_paddr_o, rsp_vaddr_o;
    logic        walk_req_valid_o;
    logic        walk_req_ready_i = 1'b0;
    logic [31:0] walk_vaddr_o;
    logic [1:0]  walk_kind_o;
    logic        walk_super_o;
    logic        walk_rsp_valid_i = 1'b0;
    logic        walk_rsp_ok_i = 1'b0;
    logic [19:0] walk_rsp_ppn_i = '0;

    int n_tests = 0;
    int n_fail  = 0;

    logic        got_valid, got_hit, got_walked, got_super;
    logic [1:0]  got_cause;
    logic [31:0] got_pa, got_va, got_wva;

    always #10 clk = ~clk;

    tlb_split_tag dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .vm_on_i(vm_on_i),
        .priv_i(priv_i), .mprv_i(mprv_i), .req_valid_i(req_valid_i),
        .req_ready_o(req_ready_o), .req_vaddr_i(req_vaddr_i), .req_kind_i(req_kind_i),
        .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_cause_o(rsp_cause_o),
        .rsp_paddr_o(rsp_paddr_o), .rsp_vaddr_o(rsp_vaddr_o),
        .walk_req_valid_o(walk_req_valid_o), .walk_req_ready_i(walk_req_ready_i),
        .walk_vaddr_o(walk_vaddr_o), .walk_kind_o(walk_kind_o), .walk_super_o(walk_super_o),
        .walk_rsp_valid_i(walk_rsp_valid_i), .walk_rsp_ok_i(walk_rsp_ok_i),
        .walk_rsp_ppn_i(walk_rsp_ppn_i)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
        end
    endtask

    // One access; acts as the walker when a walk is requested.
    task automatic access(input logic [31:0] va, input logic [1:0] kind,
                          input logic [1:0] pv, input logic [1:0] mp, input logic vm,
                          input logic ok, input logic [19:0] ppn, input logic flush_mid);
        got_valid = 0; got_hit = 0; got_walked = 0; got_super = 0;
        got_cause = 0; got_pa = 0; got_va = 0; got_wva = 0;
        @(negedge clk);
        req_valid_i = 1; req_vaddr_i = va; req_kind_i = kind;
        priv_i = pv; mprv_i = mp; vm_on_i = vm;
        @(negedge clk);
        req_valid_i = 0;
        if (rsp_valid_o) begin
            got_valid = 1; got_hit = rsp_hit_o; got_cause = rsp_cause_o;
            got_pa = rsp_paddr_o; got_va = rsp_vaddr_o;
        end else if (walk_req_valid_o) begin
            got_walked = 1; got_super = walk_super_o; got_wva = walk_vaddr_o;
            walk_req_ready_i = 1;
            @(negedge clk);
            walk_req_ready_i = 0;
            chk("R6 stall while walking", req_ready_o, 0);
            if (flush_mid) begin
                flush_i = 1;
                @(negedge clk);
                flush_i = 0;
            end
            walk_rsp_valid_i = 1; walk_rsp_ok_i = ok; walk_rsp_ppn_i = ppn;
            @(negedge clk);
            walk_rsp_valid_i = 0;
            if (rsp_valid_o) begin
                got_valid = 1; got_hit = rsp_hit_o; got_cause = rsp_cause_o;
                got_pa = rsp_paddr_o; got_va = rsp_vaddr_o;
            end
        end
    endtask

    task automatic t_reset;
        chk("R1 ready after reset", req_ready_o, 1);
        chk("R1 no response after reset", rsp_valid_o, 0);
        chk("R1 no walk after reset", walk_req_valid_o, 0);
        access(32'h0001_2345, K_LOAD, P_S, P_U, 1, 1, 20'h00ABC, 0);
        chk("R1 first access walks", got_walked, 1);
    endtask

    task automatic t_miss_refill;
        chk("R6 walk address", got_wva, 32'h0001_2345);
        chk("R7 response valid", got_valid, 1);
        chk("R7 not a hit", got_hit, 0);
        chk("R7 paddr from walker", got_pa, 32'h00AB_C345);
        chk("R7 no fault", got_cause, 0);
        access(32'h0001_2355, K_LOAD, P_S, P_U, 1, 1, 20'h0, 0);
        chk("R3 hit no walk", got_walked, 0);
        chk("R3 hit flag", got_hit, 1);
        chk("R3 hit paddr", got_pa, 32'h00AB_C355);
    endtask

    task automatic t_split_tags;
        access(32'h0001_2000, K_FETCH, P_S, P_U, 1, 1, 20'h00ABC, 0);
        chk("R4 fetch misses on load-only page", got_walked, 1);
        access(32'h0001_2008, K_LOAD, P_S, P_U, 1, 1, 20'h0, 0);
        chk("R5 equal sibling tag kept", got_hit, 1);
        access(32'h0001_2010, K_LOAD, P_S, P_U, 1, 1, 20'h0, 0);
        chk("R5 equal sibling paddr", got_pa, 32'h00AB_C010);
    endtask

    task automatic t_conflict;
        access(32'h0002_2100, K_LOAD, P_S, P_U, 1, 1, 20'h00DEF, 0);
        chk("R2 same index other page misses", got_walked, 1);
        chk("R2 new page paddr", got_pa, 32'h00DE_F100);
        access(32'h0001_2000, K_FETCH, P_S, P_U, 1, 1, 20'h00123, 0);
        chk("R5 differing sibling invalidated", got_walked, 1);
        access(32'h0002_2100, K_LOAD, P_S, P_U, 1, 0, 20'h0, 0);
        chk("R5 load tag dropped by fetch refill", got_walked, 1);
    endtask

    task automatic t_fault;
        chk("R8 load fault cause", got_cause, 2'b10);
        chk("R8 fault vaddr", got_va, 32'h0002_2100);
        chk("R8 fault not hit", got_hit, 0);
        access(32'h0001_2abc, K_FETCH, P_S, P_U, 1, 1, 20'h0, 0);
        chk("R8 fault left entry intact", got_hit, 1);
        chk("R8 intact paddr", got_pa, 32'h0012_3abc);
        access(32'h0003_5004, K_STORE, P_S, P_U, 1, 0, 20'h0, 0);
        chk("R8 store fault cause", got_cause, 2'b11);
        access(32'h0003_5004, K_FETCH, P_S, P_U, 1, 0, 20'h0, 0);
        chk("R8 fetch fault cause", got_cause, 2'b01);
        access(32'h0003_5004, K_FETCH, P_S, P_U, 1, 1, 20'h00444, 0);
        chk("R8 failed walk not installed", got_walked, 1);
    endtask

    task automatic t_super;
        access(32'h0004_0000, K_LOAD, P_U, P_U, 1, 1, 20'h00777, 0);
        chk("R12 user walk flag", got_super, 0);
        access(32'h0004_0000, K_STORE, P_M, P_S, 1, 1, 20'h00777, 0);
        chk("R12 machine with supervisor field", got_walked, 1);
        chk("R12 supervisor flag", got_super, 1);
        access(32'h0007_1000, K_LOAD, P_M, P_U, 1, 1, 20'h00055, 0);
        chk("R11 machine load user field translates", got_walked, 1);
        chk("R12 machine user field flag", got_super, 0);
    endtask

    task automatic t_bypass;
        access(32'h8765_4321, K_LOAD, P_S, P_U, 0, 1, 20'h0, 0);
        chk("R11 vm off no walk", got_walked, 0);
        chk("R11 vm off identity", got_pa, 32'h8765_4321);
        chk("R11 vm off hit flag", got_hit, 1);
        access(32'h1234_5678, K_FETCH, P_M, P_U, 1, 1, 20'h0, 0);
        chk("R11 machine fetch identity", got_pa, 32'h1234_5678);
        access(32'h0ABC_DEF0, K_STORE, P_M, P_M, 1, 1, 20'h0, 0);
        chk("R11 machine field identity", got_pa, 32'h0ABC_DEF0);
        chk("R11 machine field no walk", got_walked, 0);
    endtask

    task automatic t_flush;
        access(32'h0004_0010, K_LOAD, P_U, P_U, 1, 1, 20'h0, 0);
        chk("R9 page present before flush", got_hit, 1);
        @(negedge clk);
        flush_i = 1;
        #1;
        chk("R9 ready low during flush", req_ready_o, 0);
        @(negedge clk);
        flush_i = 0;
        access(32'h0004_0010, K_LOAD, P_U, P_U, 1, 1, 20'h00777, 0);
        chk("R9 flushed page misses", got_walked, 1);
    endtask

    task automatic t_flush_pending;
        access(32'h0009_9040, K_FETCH, P_S, P_U, 1, 1, 20'h00999, 1);
        chk("R10 reply still delivered", got_valid, 1);
        chk("R10 reply paddr", got_pa, 32'h0099_9040);
        access(32'h0009_9040, K_FETCH, P_S, P_U, 1, 1, 20'h00999, 0);
        chk("R10 stale reply not installed", got_walked, 1);
        access(32'h0009_9040, K_FETCH, P_S, P_U, 1, 1, 20'h0, 0);
        chk("R7 later refill installed", got_hit, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_miss_refill;
        t_split_tags;
        t_conflict;
        t_fault;
        t_super;
        t_bypass;
        t_flush;
        t_flush_pending;
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule